// File: doc/BRIEF.md
# Readout packet error classifier

The block watches a byte-wide stream of fixed 16-byte readout packets arriving from a concentrator that collects front-end chips. Each packet is either a trigger packet, which carries the trigger timestamp seen by one concentrator, or a data packet, which carries one chip's hit pattern. Every byte is passed straight through one cycle later. With the last byte of each packet the block presents two error vectors. The fatal vector marks damage that cannot be undone. The recoverable vector marks faults that an event builder can repair.

An event starts with a strobe that also carries the expected timestamp of the new event. The block keeps a small amount of state for each event: the expected timestamp and the one before it, the set of concentrators whose trigger packet has arrived, whether data has been seen, and a copy of the previous packet for duplicate detection. A timestamp later than expected is fatal. An earlier one is recoverable, unless it equals the previous event's timestamp, in which case the packet is classed as late data.

Packet layout:
- Byte 0: bit 7 set marks a trigger packet, bits 6:5 are reserved and must be zero, bits 4:0 hold the concentrator index.
- Bytes 1 to 3: the 24-bit timestamp, most significant byte first.
- Bytes 4 to 13: the hit pattern.
- Byte 14: bit 7 is the trigger bit.
- Byte 15: the checksum.

Top module: `rpc_pkt_classifier`

## Requirements
- R1: `in_ready` is always high. Each byte accepted with `in_valid` appears on `out_data` with `out_valid` high on the next cycle. `out_last` is high only with the 16th byte of a packet.
- R2: After reset both error vectors are zero. They are loaded in the cycle that carries a packet's last byte on the output and held unchanged until the next packet completes.
- R3: Fatal bit 5 is set when byte 15 differs from the modulo-256 sum of bytes 0 to 14, or when either reserved bit 6:5 of byte 0 is set.
- R4: Fatal bit 8 is set when byte 14 bit 7 is one while bytes 4 to 13 are not all ones.
- R5: Fatal bit 6 is set when the timestamp in bytes 1 to 3 is zero while some other byte of the packet is non-zero. A zero timestamp raises no ordering flag.
- R6: A non-zero timestamp above the current expected timestamp sets fatal bit 7. A non-zero timestamp below it sets recoverable bit 0, except for a packet flagged under R9.
- R7: Recoverable bit 2 is set when all 16 bytes equal the previous packet. The event strobe forgets the previous packet.
- R8: A trigger packet (byte 0 bit 7 set) that arrives after a data packet of the same event sets recoverable bit 3. The event strobe clears the data-seen state.
- R9: A data packet whose timestamp equals the previous event's expected timestamp, and differs from the current one, sets recoverable bit 4. Such a packet raises neither fatal bit 7 nor recoverable bit 0.
- R10: A data packet (not flagged under R9) arriving when trigger packets from some, but not all, concentrators of the event have been seen sets recoverable bit 1. The concentrator is identified by byte 0 bits 4:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Always high, the block never stalls |
| in_data | input | 8 | Input byte |
| evt_start | input | 1 | Start-of-event strobe |
| evt_ts | input | 24 | Expected timestamp of the new event, sampled with `evt_start` |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Passed-through byte |
| out_last | output | 1 | Marks the last byte of a packet |
| fatal_err | output | 9 | Fatal error vector, bits 5 to 8 used |
| recov_err | output | 5 | Recoverable error vector |

## Verification
A byte counter that slips out of step moves `out_last` and every error vector by the same offset, and it corrupts the checksum and the timestamp field at once. It is therefore visible on the very next packet. Stale per-event state shows up only when the wrong kind of packet follows. A data-seen flag that survives the strobe appears on the first trigger packet of the next event. A duplicate register that is not cleared appears only when an identical packet straddles an event boundary. The stimulus orders packets so that each of these meets the packet that exposes it right after an event strobe.

// File: rtl/rpc_pkt_pkg.sv
package rpc_pkt_pkg;
    localparam int PKT_BYTES = 16;
    localparam int PKT_W     = 8 * PKT_BYTES;
    localparam int TS_W      = 24;
    localparam int FATAL_W   = 9;
    localparam int RECOV_W   = 5;
    localparam int HIT_LO    = 4;
    localparam int HIT_N     = 10;

    // fatal vector bit positions
    localparam int F_SUM   = 5;
    localparam int F_ZTS   = 6;
    localparam int F_LATE  = 7;
    localparam int F_TRIG  = 8;
    // recoverable vector bit positions
    localparam int R_EARLY = 0;
    localparam int R_MISS  = 1;
    localparam int R_DUP   = 2;
    localparam int R_LTRIG = 3;
    localparam int R_LDATA = 4;
endpackage

// File: rtl/pkt_assembler.sv
module pkt_assembler
    import rpc_pkt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    output logic             pkt_done,
    output logic [PKT_W-1:0] pkt_flat
);
    localparam int CNT_W = $clog2(PKT_BYTES);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(PKT_BYTES - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [PKT_W-9:0] held;
    } asm_t;

    asm_t q, d;

    always_comb begin
        d = q;
        if (in_valid) begin
            if (q.cnt == LAST_IDX) begin
                d.cnt = '0;
            end else begin
                d.cnt = q.cnt + 1'b1;
                d.held[8*q.cnt +: 8] = in_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pkt_done = in_valid && (q.cnt == LAST_IDX);
    assign pkt_flat = {in_data, q.held};

    AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && q.cnt == LAST_IDX) |=> (q.cnt == '0)); // R1
    AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(q.cnt)); // R1
endmodule

// File: rtl/pkt_content_chk.sv
module pkt_content_chk
    import rpc_pkt_pkg::*;
(
    input  logic [PKT_W-1:0] pkt,
    input  logic [TS_W-1:0]  exp_ts,
    output logic [TS_W-1:0]  ts,
    output logic             is_trig,
    output logic [4:0]       conc_id,
    output logic             sum_err,
    output logic             trig_err,
    output logic             zero_ts,
    output logic             ts_late,
    output logic             ts_early
);
    logic [7:0] acc;
    logic       others_nz;

    always_comb begin
        acc = '0;
        for (int k = 0; k < PKT_BYTES - 1; k++) begin
            acc = acc + pkt[8*k +: 8];
        end
        ts        = {pkt[15:8], pkt[23:16], pkt[31:24]};
        is_trig   = pkt[7];
        conc_id   = pkt[4:0];
        sum_err   = (acc != pkt[PKT_W-1 -: 8]) || (pkt[6:5] != 2'b00);
        trig_err  = pkt[8*(PKT_BYTES-2) + 7]
                    && (pkt[8*HIT_LO +: 8*HIT_N] != {(8*HIT_N){1'b1}});
        others_nz = (pkt[7:0] != 8'h00) || (pkt[PKT_W-1:32] != '0);
        zero_ts   = (ts == '0) && others_nz;
        ts_late   = (ts != '0) && (ts > exp_ts);
        ts_early  = (ts != '0) && (ts < exp_ts);
    end
endmodule

// File: rtl/rpc_pkt_classifier.sv
module rpc_pkt_classifier
    import rpc_pkt_pkg::*;
#(
    parameter int NUM_CONC = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [7:0]          in_data,
    input  logic                evt_start,
    input  logic [TS_W-1:0]     evt_ts,
    output logic                out_valid,
    output logic [7:0]          out_data,
    output logic                out_last,
    output logic [FATAL_W-1:0]  fatal_err,
    output logic [RECOV_W-1:0]  recov_err
);
    localparam int IDX_W = (NUM_CONC > 1) ? $clog2(NUM_CONC) : 1;
    localparam logic [5:0] CONC_LIM = 6'(NUM_CONC);
    localparam logic [NUM_CONC-1:0] ALL_CONC = {NUM_CONC{1'b1}};

    typedef struct packed {
        logic                out_valid;
        logic [7:0]          out_data;
        logic                out_last;
        logic [FATAL_W-1:0]  fatal;
        logic [RECOV_W-1:0]  recov;
        logic [TS_W-1:0]     exp_ts;
        logic [TS_W-1:0]     prev_ts;
        logic                evt_ok;
        logic                prev_ok;
        logic [NUM_CONC-1:0] trig_mask;
        logic                data_seen;
        logic                dup_ok;
        logic [PKT_W-1:0]    dup_pkt;
    } cls_t;

    cls_t q, d;

    logic             pkt_done;
    logic [PKT_W-1:0] pkt_flat;
    logic [TS_W-1:0]  exp_eff;
    logic [TS_W-1:0]  pkt_ts;
    logic             is_trig, sum_err, trig_err, zero_ts, ts_late, ts_early;
    logic [4:0]       conc_id;
    logic             late_data;

    pkt_assembler u_asm (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_data  (in_data),
        .pkt_done (pkt_done),
        .pkt_flat (pkt_flat)
    );

    assign exp_eff = evt_start ? evt_ts : q.exp_ts;

    pkt_content_chk u_chk (
        .pkt      (pkt_flat),
        .exp_ts   (exp_eff),
        .ts       (pkt_ts),
        .is_trig  (is_trig),
        .conc_id  (conc_id),
        .sum_err  (sum_err),
        .trig_err (trig_err),
        .zero_ts  (zero_ts),
        .ts_late  (ts_late),
        .ts_early (ts_early)
    );

    always_comb begin
        d = q;
        d.out_valid = in_valid;
        d.out_last  = 1'b0;
        if (in_valid) d.out_data = in_data;

        // event strobe acts before a packet completing in the same cycle
        if (evt_start) begin
            d.prev_ts   = q.exp_ts;
            d.prev_ok   = q.evt_ok;
            d.exp_ts    = evt_ts;
            d.evt_ok    = 1'b1;
            d.trig_mask = '0;
            d.data_seen = 1'b0;
            d.dup_ok    = 1'b0;
        end

        late_data = !is_trig && d.prev_ok && (pkt_ts == d.prev_ts)
                    && (pkt_ts != d.exp_ts);

        if (pkt_done) begin
            d.out_last = 1'b1;
            d.fatal    = '0;
            d.recov    = '0;
            d.fatal[F_SUM]  = sum_err;
            d.fatal[F_ZTS]  = zero_ts;
            d.fatal[F_LATE] = ts_late && !late_data;
            d.fatal[F_TRIG] = trig_err;
            d.recov[R_EARLY] = ts_early && !late_data;
            d.recov[R_DUP]   = d.dup_ok && (pkt_flat == d.dup_pkt);
            d.recov[R_LDATA] = late_data;
            if (is_trig) begin
                d.recov[R_LTRIG] = d.data_seen;
                if ({1'b0, conc_id} < CONC_LIM) d.trig_mask[conc_id[IDX_W-1:0]] = 1'b1;
            end else if (!late_data) begin
                d.recov[R_MISS] = (d.trig_mask != '0) && (d.trig_mask != ALL_CONC);
                d.data_seen     = 1'b1;
            end
            d.dup_pkt = pkt_flat;
            d.dup_ok  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign in_ready  = 1'b1;
    assign out_valid = q.out_valid;
    assign out_data  = q.out_data;
    assign out_last  = q.out_last;
    assign fatal_err = q.fatal;
    assign recov_err = q.recov;

    AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid); // R1
    AST_FLAGS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !out_last |-> ($stable(fatal_err) && $stable(recov_err))); // R2
    AST_TRIG_AT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fatal_err[F_TRIG]) |-> out_last); // R4
    AST_TS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(fatal_err[F_LATE] && recov_err[R_EARLY])); // R6
    AST_SOF_CLEARS_DUP: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_start && !pkt_done) |=> !q.dup_ok); // R7
    AST_SOF_CLEARS_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_start && !pkt_done) |=> !q.data_seen); // R8
    AST_LATE_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        recov_err[R_LDATA] |-> (!recov_err[R_EARLY] && !fatal_err[F_LATE])); // R9
endmodule

// File: tb/rpc_pkt_classifier_bench.sv
module rpc_pkt_classifier_bench;
    typedef struct packed {
        logic        sof;
        logic [23:0] exp;
        logic        trig;
        logic [4:0]  id;
        logic [23:0] ts;
        logic [7:0]  fill;
        logic        tbit;
        logic        bad;
        logic        rsv;
        logic [8:0]  ef;
        logic [4:0]  en;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 24'h000100, 1'b1, 5'd0, 24'h000100, 8'h00, 1'b0, 1'b0, 1'b0, 9'h000, 5'h00}, // clean trigger
        '{1'b0, 24'h000100, 1'b1, 5'd1, 24'h000100, 8'h00, 1'b0, 1'b0, 1'b0, 9'h000, 5'h00},
        '{1'b0, 24'h000100, 1'b1, 5'd2, 24'h000100, 8'h00, 1'b0, 1'b0, 1'b0, 9'h000, 5'h00},
        '{1'b0, 24'h000100, 1'b1, 5'd3, 24'h000100, 8'h00, 1'b0, 1'b0, 1'b0, 9'h000, 5'h00},
        '{1'b0, 24'h000100, 1'b0, 5'd0, 24'h000100, 8'h5A, 1'b0, 1'b0, 1'b0, 9'h000, 5'h00}, // R10 all seen
        '{1'b0, 24'h000100, 1'b0, 5'd0, 24'h000100, 8'h5A, 1'b0, 1'b0, 1'b0, 9'h000, 5'h04}, // R7 duplicate
        '{1'b0, 24'h000100, 1'b0, 5'd0, 24'h000101, 8'h11, 1'b0, 1'b0, 1'b0, 9'h080, 5'h00}, // R6 later
        '{1'b0, 24'h000100, 1'b0, 5'd0, 24'h0000FF, 8'h22, 1'b0, 1'b0, 1'b0, 9'h000, 5'h01}, // R6 earlier
        '{1'b0, 24'h000100, 1'b0, 5'd0, 24'h000100, 8'h33, 1'b0, 1'b1, 1'b0, 9'h020, 5'h00}, // R3 checksum
        '{1'b0, 24'h000100, 1'b0, 5'd0, 24'h000100, 8'h44, 1'b0, 1'b0, 1'b1, 9'h020, 5'h00}, // R3 reserved
        '{1'b0, 24'h000100, 1'b0, 5'd0, 24'h000000, 8'h55, 1'b0, 1'b0, 1'b0, 9'h040, 5'h00}, // R5 zero ts
        '{1'b0, 24'h000100, 1'b0, 5'd0, 24'h000100, 8'h66, 1'b1, 1'b0, 1'b0, 9'h100, 5'h00}, // R4 bad pattern
        '{1'b0, 24'h000100, 1'b0, 5'd0, 24'h000100, 8'hFF, 1'b1, 1'b0, 1'b0, 9'h000, 5'h00}, // R4 all ones
        '{1'b0, 24'h000100, 1'b1, 5'd0, 24'h000100, 8'h00, 1'b0, 1'b0, 1'b0, 9'h000, 5'h08}, // R8 late trigger
        '{1'b1, 24'h000200, 1'b0, 5'd0, 24'h000100, 8'h77, 1'b0, 1'b0, 1'b0, 9'h000, 5'h10}, // R9 late data
        '{1'b0, 24'h000200, 1'b1, 5'd0, 24'h000200, 8'h00, 1'b0, 1'b0, 1'b0, 9'h000, 5'h00}, // R9 no seen
        '{1'b0, 24'h000200, 1'b0, 5'd0, 24'h000200, 8'h12, 1'b0, 1'b0, 1'b0, 9'h000, 5'h02}, // R10 missing
        '{1'b1, 24'h000300, 1'b1, 5'd0, 24'h000300, 8'h00, 1'b0, 1'b0, 1'b0, 9'h000, 5'h00}, // R8 strobe clears
        '{1'b1, 24'h000300, 1'b1, 5'd0, 24'h000300, 8'h00, 1'b0, 1'b0, 1'b0, 9'h000, 5'h00}, // R7 strobe clears
        '{1'b0, 24'h000300, 1'b0, 5'd0, 24'h000301, 8'h13, 1'b0, 1'b1, 1'b0, 9'h0A0, 5'h02}  // R3 R6 R10
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_data = '0;
    logic        evt_start = 1'b0;
    logic [23:0] evt_ts = '0;
    logic        out_valid;
    logic [7:0]  out_data;
    logic        out_last;
    logic [8:0]  fatal_err;
    logic [4:0]  recov_err;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    rpc_pkt_classifier u_rpc_pkt_classifier (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .evt_start (evt_start),
        .evt_ts    (evt_ts),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_last  (out_last),
        .fatal_err (fatal_err),
        .recov_err (recov_err)
    );

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    function automatic logic [127:0] build(input vec_t v);
        logic [127:0] p;
        logic [7:0]   s;
        p = '0;
        p[7:0]   = {v.trig, 1'b0, v.rsv, v.id};
        p[15:8]  = v.ts[23:16];
        p[23:16] = v.ts[15:8];
        p[31:24] = v.ts[7:0];
        for (int k = 4; k < 14; k++) p[8*k +: 8] = v.fill;
        p[119:112] = {v.tbit, 7'h00};
        s = '0;
        for (int k = 0; k < 15; k++) s = s + p[8*k +: 8];
        p[127:120] = s + {7'b0, v.bad};
        return p;
    endfunction

    task automatic send(input vec_t v, input int idx);
        logic [127:0] p;
        p = build(v);
        if (v.sof) begin
            @(negedge clk);
            evt_start = 1'b1;
            evt_ts    = v.exp;
            @(negedge clk);
            evt_start = 1'b0;
        end
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = p[8*k +: 8];
            if (k > 0) begin
                chk(out_valid && out_data == p[8*(k-1) +: 8] && !out_last,
                    $sformatf("R1 vec %0d byte %0d", idx, k - 1), {23'b0, out_valid, out_data}, {24'h1, p[8*(k-1) +: 8]});
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid && out_last && out_data == p[127:120],
            $sformatf("R1 vec %0d last byte", idx), {22'b0, out_valid, out_last, out_data}, {24'h3, p[127:120]});
        chk(fatal_err == v.ef, $sformatf("R2 fatal vec %0d", idx), {23'b0, fatal_err}, {23'b0, v.ef});
        chk(recov_err == v.en, $sformatf("R2 recov vec %0d", idx), {27'b0, recov_err}, {27'b0, v.en});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 reset state, R1 ready
        chk(fatal_err == '0 && recov_err == '0, "R2 reset vectors", {18'b0, fatal_err, recov_err}, 32'h0);
        chk(!out_valid && !out_last && in_ready, "R1 reset outputs", {29'b0, out_valid, out_last, in_ready}, 32'h1);

        for (int i = 0; i < NV; i++) send(VEC[i], i);

        // R2 held over idle cycles
        repeat (5) @(negedge clk);
        chk(fatal_err == 9'h0A0 && recov_err == 5'h02, "R2 hold while idle",
            {18'b0, fatal_err, recov_err}, {18'b0, 9'h0A0, 5'h02});
        chk(!out_valid && !out_last, "R1 idle outputs", {30'b0, out_valid, out_last}, 32'h0);

        // R2 strobe alone leaves vectors untouched
        evt_start = 1'b1;
        evt_ts    = 24'h000400;
        @(negedge clk);
        evt_start = 1'b0;
        @(negedge clk);
        chk(fatal_err == 9'h0A0 && recov_err == 5'h02, "R2 strobe keeps vectors",
            {18'b0, fatal_err, recov_err}, {18'b0, 9'h0A0, 5'h02});

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule